// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority (level 0 highest), raises one interrupt line towards a processor, and answers an acknowledge pulse with an 8-bit vector. The vector is a programmed base plus the winning level number. It keeps three 8-bit registers: a request register that latches rising input edges, a mask register that blocks chosen levels, and an in-service register that records the levels the processor is currently handling. The in-service register holds off requests of equal or lower priority until those levels are released.

Software reaches the block through a two-address port selected by `bus_sel`. An even-address write with data bit 4 set restarts configuration. It then takes one to three words at the odd address: the vector base, an optional cascade word, and an optional mode word whose bit 1 enables automatic release. When configuration is complete, odd writes load the mask. Even writes are end-of-interrupt commands or read-select commands. A request that goes away before it is acknowledged produces the level-7 vector and changes nothing in service, so a handler can recognise it as spurious.

The configuration sequencer has four states. `CFG_READY` moves to `CFG_BASE` on a restart write. `CFG_BASE` goes on the next odd write to `CFG_CASC`, to `CFG_MODE` or back to `CFG_READY`, depending on the single-unit and mode-word flags captured at the restart. `CFG_CASC` goes on an odd write to `CFG_MODE` or to `CFG_READY`. `CFG_MODE` returns to `CFG_READY` on an odd write. A restart write sends every state to `CFG_BASE`. The acknowledge sequencer has two states. `ACK_IDLE` moves to `ACK_DRIVE` when `ack_req` is high. `ACK_DRIVE` always returns to `ACK_IDLE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers are zero, `int_out` and `vec_valid` are low, and even-address reads return the request register.
- R2: An even write with data bit 4 set clears mask, request and in-service registers and selects the request register for reads. The next odd write is the vector base. If that restart word has bit 1 clear, a cascade word follows. If it has bit 0 set, a mode word follows. Any later odd write loads the mask.
- R3: An acknowledged level L returns vector {base[7:3], L}. For example, base 0x20 and level 3 give 0x23.
- R4: An odd write in the ready state loads the mask, and an odd read returns it. A masked level still latches in the request register but never drives `int_out` and is never chosen.
- R5: A rising edge on an input sets its request bit. The bit clears when that level is acknowledged or when the input falls before acknowledge.
- R6: `int_out` is high when some unmasked request has a lower level number than every in-service level. An acknowledge moves the lowest-numbered such request from the request register to the in-service register.
- R7: An even write of 0x60 plus L (L from 0 to 7) clears only in-service bit L.
- R8: An even write of 0x20 clears the lowest-numbered in-service bit that is set.
- R9: An even write of 0x0A selects the request register and 0x0B selects the in-service register for even reads. The choice holds until it is changed or configuration restarts.
- R10: When the mode word had bit 1 set, an acknowledge sets no in-service bit. Without a mode word this option is off.
- R11: An acknowledge with no eligible request returns {base[7:3], 7} and leaves the in-service register unchanged.
- R12: `vec_valid` is high for exactly the one cycle after the clock edge that samples `ack_req`. `vec_out` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Address select: 0 even, 1 odd |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Request inputs, bit n is level n |
| int_out | output | 1 | Interrupt to processor |
| ack_req | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Vector returned for the acknowledge |
| vec_valid | output | 1 | Vector valid strobe |

## Verification
The assertions assume that `ack_req` is a single-cycle pulse issued while no vector is being returned, and that end-of-interrupt commands do not land in the same cycle as an acknowledge whose in-service effect a property checks. They also assume that `irq_in` is low when reset is released, so no false edge is latched. The stimulus drives every input at the falling clock edge and keeps at least one idle cycle between operations. It never overlaps an acknowledge with a register write, and it holds or lowers request lines only at explicit table steps.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_IR = 8;
    localparam int IDX_W  = $clog2(NUM_IR);
    localparam int DW     = 8;
    localparam int BASE_W = DW - IDX_W;

    typedef enum logic [1:0] {
        CFG_READY,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE
    } cfg_state_e;

    typedef enum logic {
        ACK_IDLE,
        ACK_DRIVE
    } ack_state_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Lowest-numbered request bit that sits above every busy level.
    function automatic pick_t pick_level(input logic [NUM_IR-1:0] req,
                                         input logic [NUM_IR-1:0] busy);
        pick_t r;
        logic  stop;
        r    = '0;
        stop = 1'b0;
        for (int i = 0; i < NUM_IR; i++) begin
            if (!stop) begin
                if (busy[i]) begin
                    stop = 1'b1;
                end else if (req[i]) begin
                    r.hit = 1'b1;
                    r.idx = IDX_W'(i);
                    stop  = 1'b1;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_cfg_seq.sv
module irqc_cfg_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DW-1:0]     wr_data,
    output logic              init_clr,
    output logic [BASE_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic [NUM_IR-1:0] mask,
    output logic              read_isr,
    output logic              eoi_ns,
    output logic              eoi_spec,
    output logic [IDX_W-1:0]  eoi_lvl
);
    cfg_state_e        state_q, state_d;
    logic              single_q, need_mode_q;
    logic [BASE_W-1:0] base_q;
    logic              aeoi_q, risr_q;
    logic [NUM_IR-1:0] mask_q;
    logic              even_wr, odd_wr, start, ocw_a, ocw_b;

    assign even_wr = wr_en & ~wr_sel;
    assign odd_wr  = wr_en &  wr_sel;
    assign start   = even_wr & wr_data[4];
    assign ocw_a   = even_wr & ~wr_data[4] & ~wr_data[3] & (state_q == CFG_READY);
    assign ocw_b   = even_wr & ~wr_data[4] &  wr_data[3] & (state_q == CFG_READY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = CFG_BASE;
        end else begin
            unique case (state_q)
                CFG_READY: state_d = CFG_READY;
                CFG_BASE: if (odd_wr)
                    state_d = !single_q ? CFG_CASC : (need_mode_q ? CFG_MODE : CFG_READY);
                CFG_CASC: if (odd_wr)
                    state_d = need_mode_q ? CFG_MODE : CFG_READY;
                CFG_MODE: if (odd_wr)
                    state_d = CFG_READY;
            endcase
        end
    end

    // configuration and command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q    <= 1'b0;
            need_mode_q <= 1'b0;
            base_q      <= '0;
            aeoi_q      <= 1'b0;
            mask_q      <= '0;
            risr_q      <= 1'b0;
        end else if (start) begin
            single_q    <= wr_data[1];
            need_mode_q <= wr_data[0];
            aeoi_q      <= 1'b0;
            mask_q      <= '0;
            risr_q      <= 1'b0;
        end else begin
            if (odd_wr && state_q == CFG_BASE)  base_q <= wr_data[DW-1:IDX_W];
            if (odd_wr && state_q == CFG_MODE)  aeoi_q <= wr_data[1];
            if (odd_wr && state_q == CFG_READY) mask_q <= wr_data;
            if (ocw_b && wr_data[1])            risr_q <= wr_data[0];
        end
    end

    assign init_clr = start;
    assign vec_base = base_q;
    assign auto_eoi = aeoi_q;
    assign mask     = mask_q;
    assign read_isr = risr_q;
    assign eoi_ns   = ocw_a & (wr_data[7:5] == 3'b001);
    assign eoi_spec = ocw_a & (wr_data[7:5] == 3'b011);
    assign eoi_lvl  = wr_data[IDX_W-1:0];

    assert_init_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == CFG_BASE) && (mask_q == '0) && !risr_q);

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_wr && !start && state_q == CFG_READY) |=> mask_q == $past(wr_data));
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IR-1:0] irq_in,
    input  logic              init_clr,
    input  logic              take_en,
    input  logic [IDX_W-1:0]  take_idx,
    output logic [NUM_IR-1:0] irr
);
    logic [NUM_IR-1:0] prev_q, irr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            for (int i = 0; i < NUM_IR; i++) begin
                if (init_clr)                                  irr_q[i] <= 1'b0;
                else if (irq_in[i] && !prev_q[i])              irr_q[i] <= 1'b1;
                else if (!irq_in[i])                           irr_q[i] <= 1'b0;
                else if (take_en && take_idx == IDX_W'(i))     irr_q[i] <= 1'b0;
            end
        end
    end

    assign irr = irr_q;

    assert_init_clears_irr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> irr_q == '0);

    for (genvar g = 0; g < NUM_IR; g++) begin : g_bit
        assert_drop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_in[g] |=> !irr_q[g]);
    end
endmodule

// File: rtl/irqc_service.sv
module irqc_service
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IR-1:0] irr,
    input  logic [NUM_IR-1:0] mask,
    input  logic              init_clr,
    input  logic              ack_req,
    input  logic              auto_eoi,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              eoi_ns,
    input  logic              eoi_spec,
    input  logic [IDX_W-1:0]  eoi_lvl,
    output logic [NUM_IR-1:0] isr,
    output logic              int_out,
    output logic [DW-1:0]     vec_out,
    output logic              vec_valid,
    output logic              take_en,
    output logic [IDX_W-1:0]  take_idx
);
    ack_state_e        st_q, st_d;
    logic [NUM_IR-1:0] isr_q, isr_d;
    logic [DW-1:0]     vec_q;
    pick_t             win, top_busy;
    logic              ack_take;

    assign win      = pick_level(irr & ~mask, isr_q);
    assign top_busy = pick_level(isr_q, '0);
    assign ack_take = (st_q == ACK_IDLE) && ack_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ACK_IDLE:  st_d = ack_req ? ACK_DRIVE : ACK_IDLE;
            ACK_DRIVE: st_d = ACK_IDLE;
        endcase
    end

    // in-service update
    always_comb begin
        isr_d = isr_q;
        if (ack_take && win.hit && !auto_eoi) isr_d[win.idx] = 1'b1;
        if (eoi_spec)                         isr_d[eoi_lvl] = 1'b0;
        if (eoi_ns && top_busy.hit)           isr_d[top_busy.idx] = 1'b0;
        if (init_clr)                         isr_d = '0;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            vec_q <= '0;
        end else begin
            isr_q <= isr_d;
            if (ack_take)
                vec_q <= win.hit ? {vec_base, win.idx} : {vec_base, {IDX_W{1'b1}}};
        end
    end

    assign isr       = isr_q;
    assign int_out   = win.hit;
    assign vec_out   = vec_q;
    assign vec_valid = (st_q == ACK_DRIVE);
    assign take_en   = ack_take & win.hit;
    assign take_idx  = win.idx;

    assert_vec_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ACK_DRIVE |=> st_q == ACK_IDLE);

    assert_auto_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && auto_eoi) |=> (isr_q & ~$past(isr_q)) == '0);

    assert_spurious_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !win.hit && !eoi_ns && !eoi_spec && !init_clr) |=> isr_q == $past(isr_q));

    assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && win.hit && !auto_eoi && !eoi_ns && !eoi_spec && !init_clr)
            |=> isr_q[$past(win.idx)]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    irq_in,
    output logic          int_out,
    input  logic          ack_req,
    output logic [7:0]    vec_out,
    output logic          vec_valid
);
    logic              init_clr, auto_eoi, read_isr, eoi_ns, eoi_spec, take_en;
    logic [BASE_W-1:0] vec_base;
    logic [NUM_IR-1:0] mask, irr, isr;
    logic [IDX_W-1:0]  eoi_lvl, take_idx;

    irqc_cfg_seq u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_sel(bus_sel), .wr_data(bus_wdata),
        .init_clr(init_clr), .vec_base(vec_base), .auto_eoi(auto_eoi), .mask(mask),
        .read_isr(read_isr), .eoi_ns(eoi_ns), .eoi_spec(eoi_spec), .eoi_lvl(eoi_lvl)
    );

    irqc_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .init_clr(init_clr),
        .take_en(take_en), .take_idx(take_idx), .irr(irr)
    );

    irqc_service u_svc (
        .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .init_clr(init_clr),
        .ack_req(ack_req), .auto_eoi(auto_eoi), .vec_base(vec_base), .eoi_ns(eoi_ns),
        .eoi_spec(eoi_spec), .eoi_lvl(eoi_lvl), .isr(isr), .int_out(int_out),
        .vec_out(vec_out), .vec_valid(vec_valid), .take_en(take_en), .take_idx(take_idx)
    );

    assign bus_rdata = bus_sel ? mask : (read_isr ? isr : irr);

    assert_int_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (irr & ~mask) != '0);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
    localparam logic [2:0] OP_WR = 3'd0, OP_IRQ = 3'd1, OP_ACK = 3'd2, OP_RD = 3'd3, OP_INT = 3'd4;
    localparam int N = 60;
    // {op, sel, data, expected, requirement}
    localparam logic [23:0] TBL [0:N-1] = '{
        {OP_WR, 1'b0, 8'h11, 8'h00, 4'd2},  // R2 restart, cascade and mode words follow
        {OP_WR, 1'b1, 8'h20, 8'h00, 4'd2},  // R2 base
        {OP_WR, 1'b1, 8'h04, 8'h00, 4'd2},  // R2 cascade word
        {OP_WR, 1'b1, 8'h01, 8'h00, 4'd2},  // R2 mode word, no auto release
        {OP_RD, 1'b1, 8'h00, 8'h00, 4'd4},  // R4 mask clear
        {OP_IRQ,1'b0, 8'h08, 8'h00, 4'd5},  // R5 rise on level 3
        {OP_INT,1'b0, 8'h00, 8'h01, 4'd6},  // R6
        {OP_RD, 1'b0, 8'h00, 8'h08, 4'd9},  // R9 request register selected
        {OP_ACK,1'b0, 8'h00, 8'h23, 4'd3},  // R3 base 0x20 + 3
        {OP_WR, 1'b0, 8'h0B, 8'h00, 4'd9},  // R9 select in-service
        {OP_RD, 1'b0, 8'h00, 8'h08, 4'd6},  // R6 level 3 in service
        {OP_IRQ,1'b0, 8'h0A, 8'h00, 4'd6},  // rise on level 1
        {OP_INT,1'b0, 8'h00, 8'h01, 4'd6},  // R6 nests above level 3
        {OP_ACK,1'b0, 8'h00, 8'h21, 4'd6},  // R6
        {OP_RD, 1'b0, 8'h00, 8'h0A, 4'd6},  // R6
        {OP_IRQ,1'b0, 8'h0E, 8'h00, 4'd6},  // rise on level 2
        {OP_INT,1'b0, 8'h00, 8'h00, 4'd6},  // R6 blocked by level 1
        {OP_WR, 1'b0, 8'h20, 8'h00, 4'd8},  // R8 non-specific release
        {OP_RD, 1'b0, 8'h00, 8'h08, 4'd8},  // R8 level 1 cleared
        {OP_INT,1'b0, 8'h00, 8'h01, 4'd6},  // R6 level 2 now eligible
        {OP_ACK,1'b0, 8'h00, 8'h22, 4'd6},  // R6
        {OP_WR, 1'b0, 8'h63, 8'h00, 4'd7},  // R7 release level 3
        {OP_RD, 1'b0, 8'h00, 8'h04, 4'd7},  // R7 only level 3 cleared
        {OP_WR, 1'b0, 8'h62, 8'h00, 4'd7},  // R7
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd7},  // R7
        {OP_WR, 1'b0, 8'h0A, 8'h00, 4'd9},  // R9 back to request register
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd9},  // R9 acked bits gone
        {OP_IRQ,1'b0, 8'h00, 8'h00, 4'd5},
        {OP_WR, 1'b1, 8'h10, 8'h00, 4'd4},  // R4 mask level 4
        {OP_RD, 1'b1, 8'h00, 8'h10, 4'd4},  // R4
        {OP_IRQ,1'b0, 8'h10, 8'h00, 4'd4},
        {OP_INT,1'b0, 8'h00, 8'h00, 4'd4},  // R4 masked, no interrupt
        {OP_RD, 1'b0, 8'h00, 8'h10, 4'd4},  // R4 still latched
        {OP_WR, 1'b1, 8'h00, 8'h00, 4'd4},
        {OP_INT,1'b0, 8'h00, 8'h01, 4'd4},  // R4 unmasked
        {OP_IRQ,1'b0, 8'h00, 8'h00, 4'd5},  // R5 drop before ack
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd5},  // R5
        {OP_INT,1'b0, 8'h00, 8'h00, 4'd5},  // R5
        {OP_ACK,1'b0, 8'h00, 8'h27, 4'd11}, // R11 spurious vector
        {OP_WR, 1'b0, 8'h0B, 8'h00, 4'd11},
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd11}, // R11 nothing in service
        {OP_WR, 1'b0, 8'h13, 8'h00, 4'd2},  // R2 single unit, mode word follows
        {OP_WR, 1'b1, 8'h48, 8'h00, 4'd2},
        {OP_WR, 1'b1, 8'h03, 8'h00, 4'd10}, // R10 auto release
        {OP_RD, 1'b1, 8'h00, 8'h00, 4'd2},  // R2 mask cleared
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd2},
        {OP_IRQ,1'b0, 8'h80, 8'h00, 4'd10},
        {OP_ACK,1'b0, 8'h00, 8'h4F, 4'd10}, // R10 R3 base 0x48 + 7
        {OP_WR, 1'b0, 8'h0B, 8'h00, 4'd10},
        {OP_RD, 1'b0, 8'h00, 8'h00, 4'd10}, // R10 no in-service bit
        {OP_IRQ,1'b0, 8'h00, 8'h00, 4'd10},
        {OP_WR, 1'b0, 8'h12, 8'h00, 4'd2},  // R2 single unit, no mode word
        {OP_WR, 1'b1, 8'h30, 8'h00, 4'd2},
        {OP_WR, 1'b1, 8'h01, 8'h00, 4'd2},  // R2 this is now the mask
        {OP_RD, 1'b1, 8'h00, 8'h01, 4'd2},  // R2
        {OP_IRQ,1'b0, 8'h03, 8'h00, 4'd2},
        {OP_RD, 1'b0, 8'h00, 8'h03, 4'd9},  // R9 restart reselected request register
        {OP_ACK,1'b0, 8'h00, 8'h31, 4'd4},  // R4 masked level 0 skipped
        {OP_WR, 1'b0, 8'h0B, 8'h00, 4'd10},
        {OP_RD, 1'b0, 8'h00, 8'h02, 4'd10}  // R10 off without mode word
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, ack_req = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic [7:0] bus_rdata, vec_out;
    logic       int_out, vec_valid;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .int_out(int_out), .ack_req(ack_req),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_step(input logic [23:0] s);
        logic [2:0] op;
        logic [7:0] d, e;
        int r;
        op = s[23:21]; d = s[19:12]; e = s[11:4]; r = int'(s[3:0]);
        case (op)
            OP_WR: begin
                bus_sel = s[20]; bus_wdata = d; bus_wr = 1'b1;
                @(negedge clk); bus_wr = 1'b0;
            end
            OP_IRQ: begin
                irq_in = d;
                @(negedge clk);
            end
            OP_ACK: begin
                ack_req = 1'b1;
                @(negedge clk); ack_req = 1'b0;
                check(12, {7'd0, vec_valid}, 8'h01);   // R12
                check(r, vec_out, e);
                @(negedge clk);
                check(12, {7'd0, vec_valid}, 8'h00);   // R12
            end
            OP_RD: begin
                bus_sel = s[20]; #1;
                check(r, bus_rdata, e);
            end
            default: check(r, {7'd0, int_out}, e);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(1, {7'd0, int_out}, 8'h00);
        check(1, {7'd0, vec_valid}, 8'h00);
        bus_sel = 1'b1; #1; check(1, bus_rdata, 8'h00);
        bus_sel = 1'b0; #1; check(1, bus_rdata, 8'h00);
        @(negedge clk);
        for (int i = 0; i < N; i++) run_step(TBL[i]);
        // R1 reset mid-run: in-service level 1 and mask 0x01 are dropped
        irq_in = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_sel = 1'b1; #1; check(1, bus_rdata, 8'h00);
        bus_sel = 1'b0; #1; check(1, bus_rdata, 8'h00);
        check(1, {7'd0, int_out}, 8'h00);
        @(negedge clk);
        // R1 even read returns request register after reset
        irq_in = 8'h40; @(negedge clk);
        bus_sel = 1'b0; #1; check(1, bus_rdata, 8'h40);
        check(6, {7'd0, int_out}, 8'h01);      // R6
        @(negedge clk);
        run_step({OP_ACK, 1'b0, 8'h00, 8'h06, 4'd3}); // R3 base 0 after reset
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule